// File: doc/BRIEF.md
# Register Rename Map Table

This block gives each architectural register name a physical storage location for a single-issue out-of-order front end. Each incoming instruction presents two source register names and one destination name. The sources are translated through a map table to the location last assigned to that register. The destination takes the location at the head of a free list, and the map table then points the destination name at it. The location the destination held before is presented on an output, so the back end can hand it back later.

Locations return to the free list through a release port. The surrounding logic drives that port once every reader of a location has collected its value. Because every write gets a fresh location, two writes to the same name never share storage. This removes write-after-write and write-after-read conflicts, and only true read-after-write dependences remain.

The free list tracks its occupancy in a three-state register. EMPTY goes to PARTIAL on a release with no allocation. PARTIAL goes to EMPTY when the last entry is allocated with no release in the same cycle. PARTIAL goes to FULL when a release fills the last slot with no allocation. FULL goes to PARTIAL on an allocation with no release. Every other case keeps the current state. Renaming is allowed whenever the state is not EMPTY.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical location i. The free-list count equals NUM_PHYS minus NUM_ARCH, `ren_ready` is high, and the first location offered is NUM_ARCH.
- R2: `phys_src_a` and `phys_src_b` always show the current mapping of `ren_src_a` and `ren_src_b`, combinationally. This includes a mapping written by a rename in the previous cycle.
- R3: A rename fires in a cycle where `ren_valid` and `ren_ready` are both high. It takes the location shown on `phys_dst_new` (the free-list head), removes it from the free list, and from the next cycle `ren_dst` maps to it.
- R4: When an instruction reads the same register it writes, its source output shows the mapping from before its own rename.
- R5: `phys_dst_old` shows the mapping `ren_dst` held before the rename.
- R6: `ren_ready` is low exactly when `free_count` is zero. A `ren_valid` while `ren_ready` is low changes neither the map nor the count.
- R7: A release with no rename raises `free_count` by one. Released locations join the tail of the free list, so locations are handed out in first-in, first-out order.
- R8: A rename and a release in the same cycle both take effect, and `free_count` does not change.
- R9: Two renames of the same architectural register receive different locations, and `phys_dst_new` differs from `phys_dst_old` on every rename.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | An instruction asks to be renamed this cycle |
| ren_src_a | input | $clog2(NUM_ARCH) | First source architectural register |
| ren_src_b | input | $clog2(NUM_ARCH) | Second source architectural register |
| ren_dst | input | $clog2(NUM_ARCH) | Destination architectural register |
| ren_ready | output | 1 | A free location is available; the rename fires when valid |
| phys_src_a | output | $clog2(NUM_PHYS) | Location mapped to the first source |
| phys_src_b | output | $clog2(NUM_PHYS) | Location mapped to the second source |
| phys_dst_new | output | $clog2(NUM_PHYS) | Location given to the destination |
| phys_dst_old | output | $clog2(NUM_PHYS) | Location the destination held before |
| rel_valid | input | 1 | Return a location to the free list |
| rel_phys | input | $clog2(NUM_PHYS) | Location being returned |
| free_count | output | $clog2(NUM_PHYS+1) | Number of locations in the free list |

## Verification
Allocation and release can fall in the same cycle. The bench provokes this in two ways. First, it drains the free list down to one entry and then drives a rename together with a release. Second, it returns a location while the list is empty and allocates it again at once. A reference queue model judges both cases: it pops the head before it appends the returned location. The count must stay flat in the combined cycle, and later renames must receive locations in queue order.

// File: rtl/reg_rename_pkg.sv
package reg_rename_pkg;

    // Occupancy condition of the free list
    typedef enum logic [1:0] {
        FL_EMPTY   = 2'd0,
        FL_PARTIAL = 2'd1,
        FL_FULL    = 2'd2
    } fl_state_e;

endpackage

// File: rtl/rename_map.sv
module rename_map #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16,
    parameter int NUM_RD   = 3,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int PW = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_arch [NUM_RD],
    output logic [PW-1:0] rd_phys [NUM_RD],
    input  logic          wr_en,
    input  logic [AW-1:0] wr_arch,
    input  logic [PW-1:0] wr_phys
);

    logic [PW-1:0] map_q [NUM_ARCH];

    // Reset to the identity mapping; one write port updates the table
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) begin
                map_q[i] <= PW'(i);
            end
        end else if (wr_en) begin
            map_q[wr_arch] <= wr_phys;
        end
    end

    // Read ports see the table before this cycle's write
    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        assign rd_phys[g] = map_q[rd_arch[g]];
    end

endmodule

// File: rtl/rename_freelist.sv
module rename_freelist
    import reg_rename_pkg::*;
#(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16,
    localparam int PW    = $clog2(NUM_PHYS),
    localparam int CW    = $clog2(NUM_PHYS + 1),
    localparam int DEPTH = NUM_PHYS,
    localparam int INIT  = NUM_PHYS - NUM_ARCH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_req,
    input  logic          push_req,
    input  logic [PW-1:0] push_phys,
    output logic [PW-1:0] head_phys,
    output logic          avail,
    output logic [CW-1:0] count
);

    logic [PW-1:0] slot_q [DEPTH];
    logic [PW-1:0] rd_ptr_q, wr_ptr_q;
    logic [CW-1:0] cnt_q, cnt_d;
    fl_state_e     st_q, st_d;
    logic          do_pop, do_push;

    assign do_pop  = pop_req && (st_q != FL_EMPTY);
    assign do_push = push_req && ((st_q != FL_FULL) || do_pop);

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        cnt_d = cnt_q;
        if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
        if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end

    // Next occupancy state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FL_EMPTY: begin
                if (do_push) st_d = (DEPTH == 1) ? FL_FULL : FL_PARTIAL;
            end
            FL_PARTIAL: begin
                if (do_pop && !do_push && cnt_q == CW'(1))
                    st_d = FL_EMPTY;
                else if (do_push && !do_pop && cnt_q == CW'(DEPTH - 1))
                    st_d = FL_FULL;
            end
            FL_FULL: begin
                if (do_pop && !do_push) st_d = FL_PARTIAL;
            end
            default: st_d = FL_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= (INIT == 0) ? FL_EMPTY : ((INIT == DEPTH) ? FL_FULL : FL_PARTIAL);
        end else begin
            st_q <= st_d;
        end
    end

    // Queue storage, pointers and count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= (i < INIT) ? PW'(NUM_ARCH + i) : '0;
            end
            rd_ptr_q <= '0;
            wr_ptr_q <= PW'(INIT % DEPTH);
            cnt_q    <= CW'(INIT);
        end else begin
            if (do_push) begin
                slot_q[wr_ptr_q] <= push_phys;
                wr_ptr_q         <= bump(wr_ptr_q);
            end
            if (do_pop) rd_ptr_q <= bump(rd_ptr_q);
            cnt_q <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        head_phys = slot_q[rd_ptr_q];
        avail     = (st_q != FL_EMPTY);
        count     = cnt_q;
    end

endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int PW = $clog2(NUM_PHYS),
    localparam int CW = $clog2(NUM_PHYS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic [AW-1:0] ren_src_a,
    input  logic [AW-1:0] ren_src_b,
    input  logic [AW-1:0] ren_dst,
    output logic          ren_ready,
    output logic [PW-1:0] phys_src_a,
    output logic [PW-1:0] phys_src_b,
    output logic [PW-1:0] phys_dst_new,
    output logic [PW-1:0] phys_dst_old,
    input  logic          rel_valid,
    input  logic [PW-1:0] rel_phys,
    output logic [CW-1:0] free_count
);

    localparam int NUM_RD = 3;

    logic          fire;
    logic          avail;
    logic [PW-1:0] head_phys;
    logic [AW-1:0] rd_arch [NUM_RD];
    logic [PW-1:0] rd_phys [NUM_RD];

    assign fire = ren_valid && avail;

    assign rd_arch[0] = ren_src_a;
    assign rd_arch[1] = ren_src_b;
    assign rd_arch[2] = ren_dst;

    rename_map #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_PHYS (NUM_PHYS),
        .NUM_RD   (NUM_RD)
    ) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_arch (rd_arch),
        .rd_phys (rd_phys),
        .wr_en   (fire),
        .wr_arch (ren_dst),
        .wr_phys (head_phys)
    );

    rename_freelist #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_PHYS (NUM_PHYS)
    ) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_req   (fire),
        .push_req  (rel_valid),
        .push_phys (rel_phys),
        .head_phys (head_phys),
        .avail     (avail),
        .count     (free_count)
    );

    always_comb begin
        ren_ready    = avail;
        phys_src_a   = rd_phys[0];
        phys_src_b   = rd_phys[1];
        phys_dst_old = rd_phys[2];
        phys_dst_new = head_phys;
    end

endmodule

// File: rtl/reg_rename_chk.sv
module reg_rename_chk #(
    parameter int PW = 4,
    parameter int CW = 5,
    parameter int NUM_PHYS = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ren_valid,
    input logic          ren_ready,
    input logic          rel_valid,
    input logic [PW-1:0] phys_dst_new,
    input logic [PW-1:0] phys_dst_old,
    input logic [CW-1:0] free_count
);

    logic fire;
    assign fire = ren_valid && ren_ready;

    // R6: ready follows the registered count
    assert_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ren_ready == (free_count != '0));

    // R6: a stalled request leaves the count alone
    assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && !ren_ready && !rel_valid) |=> free_count == $past(free_count));

    // R3: a lone allocation consumes one entry
    assert_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !rel_valid) |=> free_count == $past(free_count) - 1'b1);

    // R7: a lone release adds one entry
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && rel_valid && free_count != CW'(NUM_PHYS)) |=> free_count == $past(free_count) + 1'b1);

    // R8: allocation and release together keep the count
    assert_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && rel_valid) |=> free_count == $past(free_count));

    // R9: new location never equals the displaced one
    assert_distinct_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> phys_dst_new != phys_dst_old);

    // R7: count never exceeds capacity
    assert_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        free_count <= CW'(NUM_PHYS));

endmodule

bind reg_rename reg_rename_chk #(
    .PW       (PW),
    .CW       (CW),
    .NUM_PHYS (NUM_PHYS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ren_valid    (ren_valid),
    .ren_ready    (ren_ready),
    .rel_valid    (rel_valid),
    .phys_dst_new (phys_dst_new),
    .phys_dst_old (phys_dst_old),
    .free_count   (free_count)
);

// File: tb/tb_reg_rename.sv
module tb_reg_rename;

    localparam int NA = 8;
    localparam int NP = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid = 1'b0;
    logic [2:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
    logic       ren_ready;
    logic [3:0] phys_src_a, phys_src_b, phys_dst_new, phys_dst_old;
    logic       rel_valid = 1'b0;
    logic [3:0] rel_phys = '0;
    logic [4:0] free_count;

    always #10 clk = ~clk;  // 50 MHz

    reg_rename #(.NUM_ARCH(NA), .NUM_PHYS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
        .ren_ready(ren_ready), .phys_src_a(phys_src_a), .phys_src_b(phys_src_b),
        .phys_dst_new(phys_dst_new), .phys_dst_old(phys_dst_old),
        .rel_valid(rel_valid), .rel_phys(rel_phys), .free_count(free_count)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference model: map array, FIFO free queue, list of displaced locations
    int mmap [NA];
    int fq [64];
    int fh = 0, ft = 0, fn = 0;
    int pend [64];
    int ph = 0, pt = 0;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic model_reset();
        for (int i = 0; i < NA; i++) mmap[i] = i;
        fh = 0; ft = 0; fn = 0; ph = 0; pt = 0;
        for (int i = NA; i < NP; i++) begin
            fq[ft % 64] = i; ft++; fn++;
        end
    endtask

    // One cycle: drive after the falling edge, compare, then commit at the rising edge
    task automatic step(bit v, int sa, int sb, int d, bit rv, int rp);
        bit fire;
        @(negedge clk);
        ren_valid = v; ren_src_a = 3'(sa); ren_src_b = 3'(sb); ren_dst = 3'(d);
        rel_valid = rv; rel_phys = 4'(rp);
        #2;
        fire = v && (fn != 0);
        chk((sa == d && fire) ? "R4 src_a" : "R2 src_a", int'(phys_src_a), mmap[sa]);
        chk((sb == d && fire) ? "R4 src_b" : "R2 src_b", int'(phys_src_b), mmap[sb]);
        chk("R6 ready", int'(ren_ready), (fn != 0) ? 1 : 0);
        chk(rv && fire ? "R8 count" : "R7 count", int'(free_count), fn);
        if (fn != 0) chk("R3 new", int'(phys_dst_new), fq[fh % 64]);
        chk("R5 old", int'(phys_dst_old), mmap[d]);
        if (fire) chk("R9 distinct", int'(phys_dst_new != phys_dst_old), 1);
        @(posedge clk);
        if (fire) begin
            pend[pt % 64] = mmap[d]; pt++;
            mmap[d] = fq[fh % 64]; fh++; fn--;
        end
        if (rv && fn < NP) begin
            fq[ft % 64] = rp; ft++; fn++;
        end
    endtask

    task automatic release_one(bit with_rename, int sa, int sb, int d);
        int p;
        p = pend[ph % 64]; ph++;
        step(with_rename, sa, sb, d, 1'b1, p);
    endtask

    // Stimulus table: {valid, src_a, src_b, dst}
    localparam int NV = 11;
    localparam logic [9:0] VEC [NV] = '{
        {1'b1, 3'd1, 3'd2, 3'd3},
        {1'b1, 3'd3, 3'd3, 3'd3},
        {1'b1, 3'd3, 3'd0, 3'd5},
        {1'b1, 3'd5, 3'd3, 3'd5},
        {1'b0, 3'd5, 3'd5, 3'd1},
        {1'b1, 3'd0, 3'd7, 3'd0},
        {1'b1, 3'd1, 3'd1, 3'd2},
        {1'b1, 3'd2, 3'd4, 3'd6},
        {1'b1, 3'd6, 3'd2, 3'd7},
        {1'b1, 3'd7, 3'd7, 3'd7},
        {1'b1, 3'd0, 3'd1, 3'd4}
    };

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #2;
        chk("R1 ready", int'(ren_ready), 1);
        chk("R1 count", int'(free_count), NP - NA);
        chk("R1 first free", int'(phys_dst_new), NA);
        for (int i = 0; i < NA; i++) begin
            @(negedge clk);
            ren_src_a = 3'(i);
            ren_dst   = 3'(NA - 1 - i);
            #2;
            chk("R1 identity", int'(phys_src_a), i);
            chk("R1 identity dst", int'(phys_dst_old), NA - 1 - i);
        end

        // Table walk: renames, same-register read/write, repeat writes, then stall (R6)
        for (int k = 0; k < NV; k++) begin
            step(VEC[k][9], int'(VEC[k][8:6]), int'(VEC[k][5:3]), int'(VEC[k][2:0]), 1'b0, 0);
        end

        // R6: map untouched after stalled requests (register 4 still identity)
        step(1'b0, 4, 7, 4, 1'b0, 0);

        // R7: release while empty restores ready
        release_one(1'b0, 0, 1, 2);
        // R8: rename and release together at count 1
        release_one(1'b1, 3, 5, 1);
        // R3 then R6: last entry used, list empty again
        step(1'b1, 1, 1, 4, 1'b0, 0);
        step(1'b1, 4, 4, 4, 1'b0, 0);

        // R7: several releases, then FIFO-ordered allocation
        release_one(1'b0, 0, 0, 0);
        release_one(1'b0, 0, 0, 0);
        release_one(1'b0, 0, 0, 0);
        step(1'b1, 4, 2, 2, 1'b0, 0);
        step(1'b1, 2, 4, 4, 1'b0, 0);
        // R8 with a non-empty list
        release_one(1'b1, 4, 2, 6);
        step(1'b1, 6, 6, 0, 1'b0, 0);
        step(1'b0, 0, 6, 1, 1'b0, 0);

        // Reset mid-run returns to the identity state (R1)
        @(negedge clk);
        rst_n = 1'b0;
        ren_valid = 1'b0; rel_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        ren_src_a = 3'd5;
        #2;
        chk("R1 re-reset map", int'(phys_src_a), 5);
        chk("R1 re-reset count", int'(free_count), NP - NA);
        step(1'b1, 2, 5, 5, 1'b0, 0);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule